// File: doc/BRIEF.md
# Table-Driven AES-128 Encryption Round Engine

This block encrypts one 128-bit block with AES-128. It runs one round on each clock. It holds the cipher state as four 32-bit columns. Each full round builds every output column from four table lookups, XORed together and then XORed with the round-key column. Only one 256-entry table is defined. The other three are byte rotations of it, and the S-box under it is computed as logic rather than written out.

Key expansion is done outside the block. Software or a neighbouring unit writes the eleven expanded round keys into a small key register file, one key per write. It then presents a plaintext and pulses `start`. The engine first adds the initial key, then runs nine full rounds and a final round without the column mix. At the end it pulses `done` and raises `valid`. The ciphertext stays on `cipherText` until the next accepted start.

Top module: `aes_tt_engine`

## Requirements
- R1: A write with `keyWe` high and `keyIdx` in 0..10 stores `keyData` as round key K(keyIdx), with K0 the whitening key and K10 the last-round key. A write with `keyIdx` from 11 to 15 changes no stored key.
- R2: Byte 0 of a block is bits 127:120, and column c occupies bits 127-32c down to 96-32c. This applies to the plaintext, to each round key and to the ciphertext.
- R3: On an accepted start the state is loaded with plaintext XOR K0. Rounds 1 to 9 then form column c as T0[top byte of column c] ^ T1[bits 23:16 of column (c+1) mod 4] ^ T2[bits 15:8 of column (c+2) mod 4] ^ T3[low byte of column (c+3) mod 4] ^ Kr column c. Here T0[a] = {2·S(a), S(a), S(a), 3·S(a)}, and Tk is T0 rotated right by 8k bits.
- R4: Round 10 uses the plain S-box bytes in the same rotating selection pattern, with no column mix, and XORs the result with K10. The ciphertext therefore matches standard AES-128.
- R5: `done` rises 11 clock edges after the edge that accepts `start`, counting that edge, and stays high for exactly one cycle.
- R6: `busy` is high from the edge that accepts `start` until the edge that raises `done`, where it falls.
- R7: A `start` while `busy` is high is ignored. It does not change the running result, its timing, or the plaintext used.
- R8: Key writes while `busy` is high are ignored. This holds for the current run and for later runs.
- R9: `cipherText` and `valid` hold their values while idle. `valid` is set together with `done` and cleared by the next accepted start.
- R10: After reset, `busy`, `done` and `valid` are 0 and `cipherText` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| keyWe | input | 1 | Round-key write strobe |
| keyIdx | input | 4 | Round-key slot to write (0..10) |
| keyData | input | 128 | Round-key value |
| start | input | 1 | Begin encrypting `plainText` (accepted when idle) |
| plainText | input | 128 | Input block, sampled on the accepting edge |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| valid | output | 1 | `cipherText` holds a finished result |
| cipherText | output | 128 | Encrypted block |

## Verification
The bench encrypts three blocks with known answers, using round keys it expands itself. A swapped column rotation, a mixed final round or a missing whitening key would give a wrong ciphertext on all three. It counts edges from start to `done`, so a round counter that is off by one shows up as 10 or 12 cycles. It pulses `start` and writes a corrupt key in the middle of a run. An engine that restarts or takes the key would finish late or produce a different block. Writes to slots 11..15 and long idle stretches expose address aliasing and an output that drifts after completion.

// File: rtl/aes_tt_pkg.sv
package aes_tt_pkg;

  localparam int NumRounds = 10;
  localparam int NumKeys   = NumRounds + 1;
  localparam int RoundIdxW = $clog2(NumKeys);
  localparam int WordW     = 32;
  localparam int NumCols   = 4;
  localparam int BlockW    = WordW * NumCols;

  typedef struct packed {
    logic                 loadState;
    logic                 doRound;
    logic                 lastRound;
    logic [RoundIdxW-1:0] roundIdx;
  } ctrlStrobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] run;
    acc = 8'h00;
    run = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ run;
      run = xtime(run);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] sq;
    res = 8'h01;
    sq  = a;
    for (int k = 0; k < 8; k++) begin
      if (k != 0) res = gfMul(res, sq);
      sq = gfMul(sq, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^
           {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  // base table entry from an S-box byte; the other three are rotations
  function automatic logic [WordW-1:0] baseEntry(input logic [7:0] s);
    return {xtime(s), s, s, xtime(s) ^ s};
  endfunction

endpackage

// File: rtl/aes_tt_ctrl.sv
module aes_tt_ctrl
  import aes_tt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        valid
);

  localparam logic [RoundIdxW-1:0] LastIdx = RoundIdxW'(NumRounds);

  logic [RoundIdxW-1:0] roundCnt;

  always_comb begin
    strobe.loadState = start && !busy;
    strobe.doRound   = busy;
    strobe.lastRound = busy && (roundCnt == LastIdx);
    strobe.roundIdx  = roundCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roundCnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.loadState) begin
        busy     <= 1'b1;
        valid    <= 1'b0;
        roundCnt <= RoundIdxW'(1);
      end else if (busy) begin
        if (roundCnt == LastIdx) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          valid <= 1'b1;
        end else begin
          roundCnt <= roundCnt + RoundIdxW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/aes_tt_datapath.sv
module aes_tt_datapath
  import aes_tt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWe,
  input  logic [3:0]        keyIdx,
  input  logic [BlockW-1:0] keyData,
  input  logic              keyLock,
  input  ctrlStrobe_t       strobe,
  input  logic [BlockW-1:0] plainText,
  output logic [BlockW-1:0] stateOut
);

  logic [BlockW-1:0] keyFile [NumKeys];
  logic [BlockW-1:0] stateReg;
  logic [BlockW-1:0] roundKey;
  logic [BlockW-1:0] nextState;
  logic [WordW-1:0]  col [NumCols];

  always_ff @(posedge clk) begin
    if (keyWe && !keyLock && (int'(keyIdx) < NumKeys))
      keyFile[keyIdx[RoundIdxW-1:0]] <= keyData;
  end

  assign roundKey = keyFile[strobe.roundIdx];

  always_comb begin
    for (int c = 0; c < NumCols; c++)
      col[c] = stateReg[BlockW-1-WordW*c -: WordW];
  end

  genvar g;
  generate
    for (g = 0; g < NumCols; g++) begin : g_col
      localparam int C1 = (g + 1) % NumCols;
      localparam int C2 = (g + 2) % NumCols;
      localparam int C3 = (g + 3) % NumCols;
      logic [7:0]       sb0, sb1, sb2, sb3;
      logic [WordW-1:0] tSum;
      logic [WordW-1:0] lastWord;
      logic [WordW-1:0] e1, e2, e3;
      always_comb begin
        sb0      = sbox(col[g][31:24]);
        sb1      = sbox(col[C1][23:16]);
        sb2      = sbox(col[C2][15:8]);
        sb3      = sbox(col[C3][7:0]);
        e1       = baseEntry(sb1);
        e2       = baseEntry(sb2);
        e3       = baseEntry(sb3);
        tSum     = baseEntry(sb0) ^ {e1[7:0], e1[31:8]} ^
                   {e2[15:0], e2[31:16]} ^ {e3[23:0], e3[31:24]};
        lastWord = {sb0, sb1, sb2, sb3};
        nextState[BlockW-1-WordW*g -: WordW] =
          (strobe.lastRound ? lastWord : tSum) ^
          roundKey[BlockW-1-WordW*g -: WordW];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stateReg <= '0;
    else if (strobe.loadState) stateReg <= plainText ^ keyFile[0];
    else if (strobe.doRound)   stateReg <= nextState;
  end

  assign stateOut = stateReg;

endmodule

// File: rtl/aes_tt_engine.sv
module aes_tt_engine
  import aes_tt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyWe,
  input  logic [3:0]   keyIdx,
  input  logic [127:0] keyData,
  input  logic         start,
  input  logic [127:0] plainText,
  output logic         busy,
  output logic         done,
  output logic         valid,
  output logic [127:0] cipherText
);

  ctrlStrobe_t strobe;

  aes_tt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done),
    .valid  (valid)
  );

  aes_tt_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .keyWe     (keyWe),
    .keyIdx    (keyIdx),
    .keyData   (keyData),
    .keyLock   (busy),
    .strobe    (strobe),
    .plainText (plainText),
    .stateOut  (cipherText)
  );

endmodule

// File: rtl/aes_tt_checker.sv
module aes_tt_checker
  import aes_tt_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         valid,
  input logic [127:0] cipherText
);

  int runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runCnt <= 0;
    else if (start && !busy) runCnt <= 0;
    else if (busy)           runCnt <= runCnt + 1;
  end

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  round_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == NumRounds));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(cipherText) && $stable(valid)));

  // R9
  valid_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (valid && !busy));

  // R7
  restart_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done) |=> (busy || done));

endmodule

bind aes_tt_engine aes_tt_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .valid      (valid),
  .cipherText (cipherText)
);

// File: tb/test_aes_tt_engine.sv
module test_aes_tt_engine;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         keyWe = 1'b0;
  logic [3:0]   keyIdx = '0;
  logic [127:0] keyData = '0;
  logic         start = 1'b0;
  logic [127:0] plainText = '0;
  logic         busy, done, valid;
  logic [127:0] cipherText;

  int errors = 0;
  int checks = 0;
  logic [127:0] rk [11];

  always #10 clk = ~clk;

  aes_tt_engine i_aes_tt_engine (
    .clk(clk), .rstN(rstN), .keyWe(keyWe), .keyIdx(keyIdx), .keyData(keyData),
    .start(start), .plainText(plainText), .busy(busy), .done(done),
    .valid(valid), .cipherText(cipherText)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference field arithmetic, written independently
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    logic [7:0] inv = 0;
    logic [7:0] r;
    if (a != 0)
      for (int b = 1; b < 256; b++)
        if (refMul(a, 8'(b)) == 8'h01) inv = 8'(b);
    r = 8'h63;
    for (int k = 0; k < 8; k++)
      r[k] = r[k] ^ inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8];
    return r;
  endfunction

  task automatic expandKey(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rcon = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {refSbox(t[31:24]), refSbox(t[23:16]), refSbox(t[15:8]), refSbox(t[7:0])};
        t[31:24] ^= rcon;
        rcon = refMul(rcon, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic writeKey(input int idx, input logic [127:0] val);
    @(negedge clk);
    keyWe = 1'b1; keyIdx = 4'(idx); keyData = val;
    @(negedge clk);
    keyWe = 1'b0;
  endtask

  task automatic loadKeys(input logic [127:0] key);
    expandKey(key);
    for (int r = 0; r < 11; r++) writeKey(r, rk[r]);
  endtask

  // start, then return edges counted up to done (inclusive of accepting edge)
  task automatic runBlock(input logic [127:0] pt, input string req, output int edges);
    @(negedge clk);
    plainText = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    checks++;
    if (!busy) begin errors++; $display("FAIL R6 actual busy=0 expected busy=1 (%s)", req); end
    while (!done && edges < 40) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic testReset();
    chk("R10 busy", 128'(busy), 0);
    chk("R10 done", 128'(done), 0);
    chk("R10 valid", 128'(valid), 0);
    chk("R10 cipherText", cipherText, 0);
  endtask

  task automatic testVector(input logic [127:0] key, input logic [127:0] pt,
                            input logic [127:0] ct, input string tag);
    int e;
    loadKeys(key);
    runBlock(pt, tag, e);
    chk({"R5 latency ", tag}, 128'(e), 11);
    chk({"R3 R4 R2 R1 ciphertext ", tag}, cipherText, ct);
    chk({"R9 valid ", tag}, 128'(valid), 1);
    @(negedge clk);
    chk({"R5 done pulse ", tag}, 128'(done), 0);
    chk({"R6 busy low ", tag}, 128'(busy), 0);
  endtask

  task automatic testRestartIgnored();
    int e;
    @(negedge clk);
    plainText = 128'h00112233445566778899aabbccddeeff; start = 1'b1;
    @(negedge clk);
    start = 1'b0; e = 1;
    repeat (3) begin @(negedge clk); e++; end
    plainText = '1; start = 1'b1;   // R7: must be ignored
    @(negedge clk); e++;
    start = 1'b0;
    while (!done && e < 40) begin @(negedge clk); e++; end
    chk("R7 latency with mid-run start", 128'(e), 11);
    chk("R7 result with mid-run start", cipherText, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
  endtask

  task automatic testKeyLock();
    int e;
    @(negedge clk);
    plainText = 128'h00112233445566778899aabbccddeeff; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    keyWe = 1'b1; keyIdx = 4'd5; keyData = 128'hdeadbeef;  // R8
    @(negedge clk);
    keyWe = 1'b0; e = 2;
    while (!done && e < 40) begin @(negedge clk); e++; end
    chk("R8 result with write during run", cipherText, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    runBlock(128'h00112233445566778899aabbccddeeff, "R8 rerun", e);
    chk("R8 key slot unchanged on later run", cipherText, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
  endtask

  task automatic testHighIdx();
    int e;
    for (int i = 11; i < 16; i++) writeKey(i, 128'h0123456789abcdef0123456789abcdef);
    runBlock(128'h00112233445566778899aabbccddeeff, "R1 idx", e);
    chk("R1 slots 11..15 ignored", cipherText, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
  endtask

  task automatic testHold();
    logic [127:0] snap;
    snap = cipherText;
    repeat (20) @(negedge clk);
    chk("R9 cipherText held idle", cipherText, snap);
    chk("R9 valid held idle", 128'(valid), 1);
    @(negedge clk);
    plainText = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 valid cleared by start", 128'(valid), 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testVector(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
               128'h69c4e0d86a7b0430d8cdb78070b4c55a, "std");
    testVector('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "zero");
    testVector(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
               128'h3925841d02dc09fbdc118597196a0b32, "alt");
    loadKeys(128'h000102030405060708090a0b0c0d0e0f);
    testRestartIgnored();
    testKeyLock();
    testHighIdx();
    testHold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule